// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-driven master for the two-wire management bus that sets up external Ethernet PHYs. Each transaction is one frame. Software loads a 32-bit command word that holds a go bit, a framing select (short-form or extended-form start code), a two-bit opcode, a 5-bit port address, a 5-bit register or device address and a 16-bit payload. The block then shifts the frame out on MDC/MDIO and, for read opcodes, gathers the 16 bits that the PHY returns. The go bit reads back as 1 until the frame has finished.

A second register holds the bus settings: the MDC half-period in system clocks, the MDC edge on which returned data is sampled, and a latch delay of 0 to 7 system clocks that moves the sample point later. The same register reports an idle flag and the most recent read result. A multi-frame sequence, such as an extended-form address frame followed by a read frame, is built by software as separate transactions.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command register (byte offset 0) reads 0. The settings register (byte offset 4) reads a half-period of DEF_THRES (default 20) in bits 31:24, 0 in bits 23:20, 1 in bit 16 (idle) and 0 in bits 15:0. MDC is low and MDIO is not driven.
- R2: A write to offset 0 with bit 31 set, made while the block is idle, starts a frame. From the next cycle, bit 31 of offset 0 reads 1 and bit 16 of offset 4 reads 0. Let H be bits 31:24 of offset 4, with 0 treated as 1. The idle flag returns to 1 exactly 128·H+1 cycles after the accepted write. For a read frame with falling-edge sampling, the latch delay L is added to that count.
- R3: The frame is sent MSB first as 64 bits: 32 ones; then the start code, which is 01 when command bit 28 is 1 and 00 when it is 0; then opcode bits 27:26, port address bits 25:21, register or device address bits 20:16, a 2-bit turnaround and data bits 15:0. MDIO changes only when MDC falls.
- R4: A frame with opcode bit 27 equal to 0 (write or address) drives all 64 bits and sends 10 as the turnaround. A frame with opcode bit 27 equal to 1 (read) releases MDIO from bit 46, which is the first turnaround bit, to the end of the frame. MDIO is released whenever the block is idle.
- R5: MDC holds each level for H system clocks. MDC is low whenever the block is idle.
- R6: During a read frame, MDIO is sampled for frame bits 48 to 63. When bit 23 is 0, sampling happens at the rising MDC edge; when it is 1, at the falling edge. The sample is taken L (bits 22:20) system clocks after that edge. The 16 sampled bits, MSB first, appear in offset 4 bits 15:0 once the frame ends.
- R7: A write to offset 0 while a frame is in progress has no effect: the frame on the wire is unchanged and offset 0 bits 30:0 keep the accepted command.
- R8: Offset 4 bits 15:0 change only when a read frame completes. A write or address frame leaves them unchanged.
- R9: Bits 31:20 of a write to offset 4 set the half-period, the edge select and the latch delay, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset (0 command, 4 settings) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The busy bit and the cleared idle flag are due one cycle after the clock edge that accepts the command, and the bench reads them at the negative edge that follows. Completion is due 128·H+1 edges after acceptance, plus L for a falling-edge read. The bench counts edges one at a time while polling the idle flag, and compares the count with that formula. The wire bits and output enables are captured on every MDC rising edge, while MDIO is stable, and are compared with a frame built by the bench once the frame is over. The bench PHY changes MDIO three system clocks after MDC falls, so falling-edge reads use a latch delay of at most two.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int HALF_W     = 8;
  localparam int LAT_W      = 3;

  // command word field positions
  localparam int CB_GO    = 31;
  localparam int CB_C22   = 28;
  localparam int CB_OP_HI = 27;
  localparam int CB_OP_LO = 26;
  localparam int CB_PA_HI = 25;
  localparam int CB_PA_LO = 21;
  localparam int CB_RA_HI = 20;
  localparam int CB_RA_LO = 16;

  // settings word field positions
  localparam int SB_HALF_HI = 31;
  localparam int SB_HALF_LO = 24;
  localparam int SB_EDGE    = 23;
  localparam int SB_LAT_HI  = 22;
  localparam int SB_LAT_LO  = 20;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RUN  = 2'd1,
    FR_TAIL = 2'd2
  } fr_state_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic             short_form,
    input logic [1:0]       opc,
    input logic [4:0]       port_adr,
    input logic [4:0]       reg_adr,
    input logic [DATA_W-1:0] payload
  );
    logic [1:0] turn;
    logic [DATA_W-1:0] body;
    turn = opc[1] ? 2'b11 : 2'b10;
    body = opc[1] ? {DATA_W{1'b1}} : payload;
    return {32'hFFFF_FFFF, 1'b0, short_form, opc, port_adr, reg_adr, turn, body};
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] half_cfg,
  output logic          mdc,
  output logic          rise_evt,
  output logic          fall_evt
);

  logic [TW-1:0] cnt_q, cnt_d, lim;
  logic          mdc_d, hit;

  always_comb begin
    lim   = (half_cfg == '0) ? '0 : half_cfg - 1'b1;
    hit   = run && (cnt_q == lim);
    cnt_d = cnt_q;
    mdc_d = mdc;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (hit) begin
      cnt_d = '0;
      mdc_d = ~mdc;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign rise_evt = hit && !mdc;
  assign fall_evt = hit && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end

endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_in,
  input  logic                  fall_evt,
  input  logic                  sample_busy,
  output logic                  run,
  output logic                  busy,
  output logic                  done,
  output logic [IDX_W-1:0]      bit_idx,
  output logic                  is_read,
  output logic                  mdio_o,
  output logic                  mdio_oe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);

  fr_state_t             state_q, state_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  rd_q, rd_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rd_d    = rd_q;
    case (state_q)
      FR_IDLE: begin
        if (start) begin
          sh_d    = frame_in;
          idx_d   = '0;
          rd_d    = rd_in;
          state_d = FR_RUN;
        end
      end
      FR_RUN: begin
        if (fall_evt) begin
          if (idx_q == LAST_IDX) begin
            state_d = FR_TAIL;
          end else begin
            idx_d = idx_q + 1'b1;
            sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
      FR_TAIL: begin
        if (!sample_busy) state_d = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      rd_q    <= rd_d;
    end
  end

  assign run     = (state_q == FR_RUN);
  assign busy    = (state_q != FR_IDLE);
  assign done    = (state_q == FR_TAIL) && !sample_busy;
  assign bit_idx = idx_q;
  assign is_read = rd_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = run && (!rd_q || (idx_q < TA_IDX));

endmodule

// File: rtl/mdio_sampler.sv
module mdio_sampler #(
  parameter int LW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_evt,
  input  logic          fall_evt,
  input  logic          edge_sel,
  input  logic [LW-1:0] lat,
  input  logic          window,
  input  logic          mdio_i,
  output logic          pending,
  output logic [DW-1:0] rx
);

  logic          pend_q, pend_d, hit, cap;
  logic [LW-1:0] lc_q, lc_d;
  logic [DW-1:0] rx_q, rx_d;

  always_comb begin
    hit    = window && (edge_sel ? fall_evt : rise_evt);
    pend_d = pend_q;
    lc_d   = lc_q;
    cap    = 1'b0;
    if (pend_q) begin
      if (lc_q == LW'(1)) begin
        cap    = 1'b1;
        pend_d = 1'b0;
      end else begin
        lc_d = lc_q - 1'b1;
      end
    end
    if (hit) begin
      if (lat == '0) begin
        cap = 1'b1;
      end else begin
        pend_d = 1'b1;
        lc_d   = lat;
      end
    end
    rx_d = cap ? {rx_q[DW-2:0], mdio_i} : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lc_q   <= '0;
      rx_q   <= '0;
    end else begin
      pend_q <= pend_d;
      lc_q   <= lc_d;
      rx_q   <= rx_d;
    end
  end

  assign pending = pend_q;
  assign rx      = rx_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter int unsigned DEF_THRES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);
  localparam logic [IDX_W-1:0]  DATA_IDX = IDX_W'(DATA_POS);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  logic              ctrl_wr, data_wr, start;
  logic [30:0]       ctrl_q, ctrl_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              edge_q, edge_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  logic              fr_run, fr_busy, fr_done, fr_read, smp_pend, win;
  logic              rise_evt, fall_evt;
  logic [IDX_W-1:0]  fr_idx;
  logic [DATA_W-1:0] rx_word;
  logic [FRAME_BITS-1:0] frame_w;

  assign ctrl_wr = reg_we && (reg_addr == CTRL_OFS);
  assign data_wr = reg_we && (reg_addr == DATA_OFS);
  assign start   = ctrl_wr && reg_wdata[CB_GO] && !fr_busy;
  assign frame_w = build_frame(reg_wdata[CB_C22], reg_wdata[CB_OP_HI:CB_OP_LO],
                               reg_wdata[CB_PA_HI:CB_PA_LO],
                               reg_wdata[CB_RA_HI:CB_RA_LO],
                               reg_wdata[DATA_W-1:0]);
  assign win     = fr_run && fr_read && (fr_idx >= DATA_IDX);

  always_comb begin
    ctrl_d = ctrl_q;
    half_d = half_q;
    edge_d = edge_q;
    lat_d  = lat_q;
    rd_d   = rd_q;
    if (start) ctrl_d = reg_wdata[30:0];
    if (data_wr) begin
      half_d = reg_wdata[SB_HALF_HI:SB_HALF_LO];
      edge_d = reg_wdata[SB_EDGE];
      lat_d  = reg_wdata[SB_LAT_HI:SB_LAT_LO];
    end
    if (fr_done && fr_read) rd_d = rx_word;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      half_q <= HALF_W'(DEF_THRES);
      edge_q <= 1'b0;
      lat_q  <= '0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      half_q <= half_d;
      edge_q <= edge_d;
      lat_q  <= lat_d;
      rd_q   <= rd_d;
    end
  end

  always_comb begin
    case (reg_addr)
      CTRL_OFS: reg_rdata = {fr_busy, ctrl_q};
      DATA_OFS: reg_rdata = {half_q, edge_q, lat_q, 3'b000, !fr_busy, rd_q};
      default:  reg_rdata = '0;
    endcase
  end

  mdio_clkdiv #(.TW(HALF_W)) u_clkdiv (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (fr_run),
    .half_cfg (half_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_framer u_framer (
    .clk         (clk),
    .rst_n       (srst_n),
    .start       (start),
    .frame_in    (frame_w),
    .rd_in       (reg_wdata[CB_OP_HI]),
    .fall_evt    (fall_evt),
    .sample_busy (smp_pend),
    .run         (fr_run),
    .busy        (fr_busy),
    .done        (fr_done),
    .bit_idx     (fr_idx),
    .is_read     (fr_read),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );

  mdio_sampler #(.LW(LAT_W), .DW(DATA_W)) u_sampler (
    .clk      (clk),
    .rst_n    (srst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .edge_sel (edge_q),
    .lat      (lat_q),
    .window   (win),
    .mdio_i   (mdio_i),
    .pending  (smp_pend),
    .rx       (rx_word)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic        go_bit,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [5:0]  bit_idx,
  input logic [30:0] ctrl_q,
  input logic [15:0] rd_q
);

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_wr && go_bit)); // R2

  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < 6'd32) |-> mdio_o); // R3

  AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_q)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rd_q)); // R8

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .ctrl_wr (ctrl_wr),
  .go_bit  (reg_wdata[31]),
  .busy    (fr_busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .bit_idx (fr_idx),
  .ctrl_q  (ctrl_q),
  .rd_q    (rd_q)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int PHY_DLY    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] phy_val = 16'h0;
  int          falls = 0;
  int          rises = 0;
  logic [63:0] wire_bits, wire_oe;
  time         t_r0, t_r1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: presents the next bit a few clocks after MDC falls
  always @(negedge mdc) begin
    int n;
    falls = falls + 1;
    n = falls;
    repeat (PHY_DLY) @(posedge clk);
    mdio_i <= (n >= 48 && n <= 63) ? phy_val[63-n] : 1'b1;
  end

  // wire monitor
  always @(posedge mdc) begin
    if (rises < 64) begin
      wire_bits[rises] = mdio_o;
      wire_oe[rises]   = mdio_oe;
    end
    if (rises == 0) t_r0 = $time;
    if (rises == 1) t_r1 = $time;
    rises = rises + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input bit c22, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    logic [1:0] st;
    st = c22 ? 2'b01 : 2'b00;
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  task automatic run_op(input bit c22, input logic [1:0] op, input logic [4:0] pa,
      input logic [4:0] ra, input logic [15:0] d, input logic [15:0] pv,
      input logic [7:0] th, input bit ed, input logic [2:0] lt, input bit poke);
    logic [31:0] v, cw;
    logic [15:0] prev;
    logic [63:0] f;
    int h, nexp, cnt, bad_bits, bad_oe;
    bit isrd;
    h = (th == 0) ? 1 : int'(th);
    isrd = op[1];
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = {th, ed, lt, 20'h0};
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd4, v);
    check(v[31:20] == {th, ed, lt}, "R9", "settings readback", v[31:20], {th, ed, lt});
    prev = v[15:0];
    phy_val = pv; falls = 0; rises = 0;
    cw = {1'b1, 2'b00, c22, op, pa, ra, d};
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = cw;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd0, v);
    check(v[31] == 1'b1, "R2", "go bit while busy", v[31], 1);
    rd(3'd4, v);
    check(v[16] == 1'b0, "R2", "idle flag while busy", v[16], 0);
    if (poke) begin
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = cw ^ 32'h03FF_FFFF;
    end
    cnt = 0;
    forever begin
      @(negedge clk);
      reg_we = 1'b0;
      cnt++;
      rd(3'd4, v);
      if (v[16] || cnt > 20000) break;
    end
    nexp = 128*h + 1 + ((isrd && ed) ? int'(lt) : 0);
    check(cnt == nexp, "R2", "cycles to idle", cnt, nexp);
    f = exp_frame(c22, op, pa, ra, d);
    bad_bits = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      bit eo;
      eo = !isrd || (i < 46);
      if (wire_oe[i] !== eo) bad_oe++;
      if (eo && wire_bits[i] !== f[63-i]) bad_bits++;
    end
    check(rises == 64, "R3", "MDC cycles per frame", rises, 64);
    check(bad_bits == 0, "R3", "wrong frame bits", bad_bits, 0);
    check(bad_oe == 0, "R4", "wrong drive enables", bad_oe, 0);
    if (isrd) check(v[15:0] == pv, "R6", "read data", v[15:0], pv);
    else      check(v[15:0] == prev, "R8", "read data after write", v[15:0], prev);
    if (poke) begin
      rd(3'd0, v);
      check(v[30:0] == cw[30:0], "R7", "command kept", v[30:0], cw[30:0]);
    end
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R5", "bus quiet after frame", {mdc, mdio_oe}, 0);
    check((t_r1 - t_r0) == time'(2*h*CLK_PERIOD), "R5", "MDC period",
          t_r1 - t_r0, 2*h*CLK_PERIOD);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    check(v == 32'h0, "R1", "command after reset", v, 0);
    rd(3'd4, v);
    check(v == {8'd20, 1'b0, 3'd0, 3'b000, 1'b1, 16'h0}, "R1", "settings after reset",
          v, {8'd20, 1'b0, 3'd0, 3'b000, 1'b1, 16'h0});
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "bus after reset", {mdc, mdio_oe}, 0);

    // directed corners
    run_op(1'b1, 2'b01, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 8'd4, 1'b0, 3'd0, 1'b0);
    run_op(1'b1, 2'b10, 5'h01, 5'h02, 16'h0000, 16'h8001, 8'd4, 1'b0, 3'd0, 1'b0);
    run_op(1'b0, 2'b00, 5'h03, 5'h07, 16'h1234, 16'hFFFF, 8'd5, 1'b0, 3'd0, 1'b0);
    run_op(1'b0, 2'b11, 5'h03, 5'h07, 16'h0000, 16'h5AF0, 8'd6, 1'b1, 3'd2, 1'b0);
    run_op(1'b0, 2'b10, 5'h10, 5'h1E, 16'h0000, 16'hC3C3, 8'd5, 1'b0, 3'd3, 1'b1);
    run_op(1'b1, 2'b01, 5'h00, 5'h1F, 16'hFFFF, 16'h0000, 8'd0, 1'b0, 3'd0, 1'b1);
    run_op(1'b0, 2'b11, 5'h15, 5'h0A, 16'h0000, 16'h0001, 8'd4, 1'b1, 3'd0, 1'b0);

    // constrained random
    for (int k = 0; k < 20; k++) begin
      bit c22, ed, pk;
      logic [1:0] op;
      logic [7:0] th;
      logic [2:0] lt;
      c22 = 1'($urandom);
      op  = c22 ? ((($urandom % 2) == 0) ? 2'b01 : 2'b10) : 2'($urandom);
      th  = 8'(4 + ($urandom % 5));
      ed  = 1'($urandom);
      lt  = ed ? 3'($urandom % 3) : 3'($urandom % 4);
      pk  = 1'($urandom);
      run_op(c22, op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
             th, ed, lt, pk);
    end

    summary();
    $finish;
  end

endmodule